// File: doc/BRIEF.md
# Zero-Crossing Stepped Digital Gain

This block scales a stream of 16-bit two's-complement voice samples by a programmable gain. The gain is chosen by a 5-bit code in steps of 1.5 dB, from -34.5 dB up to +12 dB, with code 23 as unity. It sits between a data converter and a serial port and handles one sample per frame, marked by a one-cycle valid strobe. The output is registered three clock cycles after each accepted sample.

A newly written code does not take effect at once. It is held as a pending request until the signal crosses zero, so that level changes do not cause audible clicks. If no crossing comes, the pending code is forced in after a fixed number of frames. An active-low mute input forces the output sample to zero for any frame it covers. Gain tracking and crossing detection keep running while the output is muted.

Top module: `zc_gain_stage`

## Requirements
- R1: Code c selects a gain of (c - 23) x 1.5 dB. The coefficient is round(4096 x 10^(gain/20)), an unsigned Q4.12 value. The output is floor((sample x coefficient + 2048) / 4096), so code 23 passes samples unchanged and a zero input gives a zero output.
- R2: Each cycle with in_valid high produces exactly one cycle of out_valid, three clock cycles later. No out_valid appears without a matching in_valid.
- R3: Results above +32767 come out as +32767, and results below -32768 come out as -32768. The output never wraps around, and its sign never flips relative to the input.
- R4: After reset the applied code is 23 (0 dB) and no request is pending. out_valid and out_sample are 0. The previous-sample sign is taken as non-negative.
- R5: A write on gain_wr does not change the gain of any sample accepted before the applying crossing or timeout. A write in the same cycle as in_valid affects only later samples.
- R6: An accepted sample is a zero crossing if it equals zero, or if its sign bit differs from that of the previous accepted sample. A pending code is applied starting with that crossing sample itself.
- R7: If no crossing occurs, a pending code is applied starting with the 256th sample accepted after the write.
- R8: A write made while a request is still pending replaces the pending code and restarts the frame count. The earlier code is never applied.
- R9: A sample accepted with mute_n = 0 produces an output of 0. Such a sample still counts for crossing detection and for the timeout, so a pending code can be applied at a muted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle strobe marking a new input sample |
| in_sample | input | 16 | Signed input sample |
| gain_code | input | 5 | Requested gain code |
| gain_wr | input | 1 | Write strobe for gain_code |
| mute_n | input | 1 | 0 mutes the sample taken with in_valid, 1 passes it |
| out_valid | output | 1 | Strobe marking a new output sample |
| out_sample | output | 16 | Scaled, rounded and saturated output sample |

## Verification
The bench builds the block with its default parameters: a 16-bit sample, a 5-bit code, a Q4.12 coefficient and a 256-frame timeout. With only 32 codes, every code can be swept against small, mid-scale and full-scale samples of both signs. This covers the whole coefficient table, the rounding, and saturation at both rails. A 256-frame timeout is short enough to run out in full twice: once plainly, and once after a rewrite 100 frames into a pending request. Each timeout is checked frame by frame. Expected outputs are worked out in the bench from the dB formula in real arithmetic, together with an expected code chosen for each scenario.

// File: rtl/zc_gain_pkg.sv
package zc_gain_pkg;

  // Why the controller chose the code for the sample now being accepted
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_CROSS = 2'd1,
    UPD_FORCE = 2'd2
  } upd_e;

  // Linear coefficient for a gain code, rounded to nearest in fixed point
  function automatic int unsigned gain_coef(input int code, input int unity_code,
                                            input int frac_bits, input real step_db);
    real db;
    real lin;
    db  = real'(code - unity_code) * step_db;
    lin = (2.0 ** frac_bits) * (10.0 ** (db / 20.0));
    return $rtoi(lin + 0.5);
  endfunction

endpackage

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl #(
  parameter int SAMPLE_W       = 16,
  parameter int CODE_W         = 5,
  parameter int TIMEOUT_FRAMES = 256,
  parameter int RESET_CODE     = 23
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                gain_wr,
  input  logic [CODE_W-1:0]   gain_code,
  output logic [CODE_W-1:0]   eff_code,
  output logic [CODE_W-1:0]   applied_code,
  output logic                pending
);
  import zc_gain_pkg::*;

  localparam int CNT_W = (TIMEOUT_FRAMES > 1) ? $clog2(TIMEOUT_FRAMES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_FRAMES - 1);

  logic              prev_neg;
  logic [CNT_W-1:0]  wait_cnt;
  logic [CODE_W-1:0] pend_code;
  logic              crossing;
  logic              expired;
  upd_e              reason;

  always_comb begin
    crossing = (in_sample == '0) || (in_sample[SAMPLE_W-1] != prev_neg);
    expired  = (wait_cnt == LAST_CNT);
    if (!(in_valid && pending)) reason = UPD_HOLD;
    else if (crossing)          reason = UPD_CROSS;
    else if (expired)           reason = UPD_FORCE;
    else                        reason = UPD_HOLD;
    eff_code = (reason != UPD_HOLD) ? pend_code : applied_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_neg     <= 1'b0;
      applied_code <= CODE_W'(RESET_CODE);
      pend_code    <= CODE_W'(RESET_CODE);
      pending      <= 1'b0;
      wait_cnt     <= '0;
    end else begin
      if (in_valid) begin
        prev_neg     <= in_sample[SAMPLE_W-1];
        applied_code <= eff_code;
      end
      if (gain_wr) begin
        pending   <= 1'b1;
        pend_code <= gain_code;
        wait_cnt  <= '0;
      end else if (reason != UPD_HOLD) begin
        pending  <= 1'b0;
        wait_cnt <= '0;
      end else if (in_valid && pending) begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/zc_gain_rom.sv
module zc_gain_rom #(
  parameter int  CODE_W     = 5,
  parameter int  COEF_W     = 16,
  parameter int  FRAC_BITS  = 12,
  parameter int  UNITY_CODE = 23,
  parameter real STEP_DB    = 1.5
) (
  input  logic              clk,
  input  logic [CODE_W-1:0] addr,
  output logic [COEF_W-1:0] coef
);
  localparam int DEPTH = 1 << CODE_W;

  logic [COEF_W-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign table_q[g] = COEF_W'(zc_gain_pkg::gain_coef(g, UNITY_CODE, FRAC_BITS, STEP_DB));
  end

  always_ff @(posedge clk) begin
    coef <= table_q[addr];
  end

endmodule

// File: rtl/zc_gain_mul.sv
module zc_gain_mul #(
  parameter int SAMPLE_W  = 16,
  parameter int COEF_W    = 16,
  parameter int FRAC_BITS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_i,
  input  logic                mute_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [COEF_W-1:0]   coef_i,
  output logic                valid_o,
  output logic [SAMPLE_W-1:0] sample_o
);
  localparam int PROD_W = SAMPLE_W + COEF_W + 1;
  localparam logic signed [PROD_W-1:0] HALF  = PROD_W'(1) << (FRAC_BITS - 1);
  localparam logic signed [PROD_W-1:0] MAX_P = (PROD_W'(1) << (SAMPLE_W - 1)) - PROD_W'(1);
  localparam logic signed [PROD_W-1:0] MIN_P = ~MAX_P;
  localparam logic [SAMPLE_W-1:0] OUT_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] OUT_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] rounded;
  logic [SAMPLE_W-1:0]      clipped;

  always_comb begin
    prod    = PROD_W'($signed(sample_i)) * PROD_W'($signed({1'b0, coef_i}));
    rounded = (prod + HALF) >>> FRAC_BITS;
    if (rounded > MAX_P)      clipped = OUT_MAX;
    else if (rounded < MIN_P) clipped = OUT_MIN;
    else                      clipped = rounded[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) sample_o <= mute_i ? '0 : clipped;
    end
  end

endmodule

// File: rtl/zc_gain_stage.sv
module zc_gain_stage #(
  parameter int  SAMPLE_W       = 16,
  parameter int  CODE_W         = 5,
  parameter int  COEF_W         = 16,
  parameter int  FRAC_BITS      = 12,
  parameter int  TIMEOUT_FRAMES = 256,
  parameter int  UNITY_CODE     = 23,
  parameter real STEP_DB        = 1.5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [CODE_W-1:0]   gain_code,
  input  logic                gain_wr,
  input  logic                mute_n,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample
);
  logic [CODE_W-1:0]   eff_code;
  logic [CODE_W-1:0]   applied_code;
  logic                pending;

  logic                a_valid;
  logic                a_mute;
  logic [SAMPLE_W-1:0] a_sample;
  logic [CODE_W-1:0]   a_code;

  logic                b_valid;
  logic                b_mute;
  logic [SAMPLE_W-1:0] b_sample;
  logic [COEF_W-1:0]   b_coef;

  zc_gain_ctrl #(
    .SAMPLE_W      (SAMPLE_W),
    .CODE_W        (CODE_W),
    .TIMEOUT_FRAMES(TIMEOUT_FRAMES),
    .RESET_CODE    (UNITY_CODE)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_sample   (in_sample),
    .gain_wr     (gain_wr),
    .gain_code   (gain_code),
    .eff_code    (eff_code),
    .applied_code(applied_code),
    .pending     (pending)
  );

  // Stage A: capture the sample with the code chosen for it
  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid  <= 1'b0;
      a_mute   <= 1'b1;
      a_sample <= '0;
      a_code   <= CODE_W'(UNITY_CODE);
    end else begin
      a_valid <= in_valid;
      if (in_valid) begin
        a_mute   <= ~mute_n;
        a_sample <= in_sample;
        a_code   <= eff_code;
      end
    end
  end

  zc_gain_rom #(
    .CODE_W    (CODE_W),
    .COEF_W    (COEF_W),
    .FRAC_BITS (FRAC_BITS),
    .UNITY_CODE(UNITY_CODE),
    .STEP_DB   (STEP_DB)
  ) u_rom (
    .clk (clk),
    .addr(a_code),
    .coef(b_coef)
  );

  // Stage B: sample travels alongside the coefficient lookup
  always_ff @(posedge clk) begin
    if (rst) begin
      b_valid  <= 1'b0;
      b_mute   <= 1'b1;
      b_sample <= '0;
    end else begin
      b_valid  <= a_valid;
      b_mute   <= a_mute;
      b_sample <= a_sample;
    end
  end

  zc_gain_mul #(
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .FRAC_BITS(FRAC_BITS)
  ) u_mul (
    .clk     (clk),
    .rst     (rst),
    .valid_i (b_valid),
    .mute_i  (b_mute),
    .sample_i(b_sample),
    .coef_i  (b_coef),
    .valid_o (out_valid),
    .sample_o(out_sample)
  );

endmodule

// File: rtl/zc_gain_stage_chk.sv
module zc_gain_stage_chk #(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_sample,
  input logic                mute_n,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_sample,
  input logic [CODE_W-1:0]   applied_code,
  input logic                pending
);

  assert_out_follows_in_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##2 out_valid);

  assert_no_stray_out_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##2 !out_valid);

  assert_mute_forces_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mute_n) |=> ##2 (out_sample == '0));

  assert_no_sign_flip_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sample[SAMPLE_W-1]) |=> ##2 !out_sample[SAMPLE_W-1]);

  assert_zero_stays_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sample == '0) |=> ##2 (out_sample == '0));

  assert_idle_gain_held_R5: assert property (@(posedge clk) disable iff (rst)
    !pending |=> $stable(applied_code));

  assert_gain_moves_on_sample_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(applied_code));

endmodule

bind zc_gain_stage zc_gain_stage_chk #(
  .SAMPLE_W(SAMPLE_W),
  .CODE_W  (CODE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_sample   (in_sample),
  .mute_n      (mute_n),
  .out_valid   (out_valid),
  .out_sample  (out_sample),
  .applied_code(applied_code),
  .pending     (pending)
);

// File: tb/zc_gain_stage_bench.sv
`timescale 1ns/1ps
module zc_gain_stage_bench;
  localparam int UNITY = 23;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic [4:0]  gain_code = '0;
  logic        gain_wr = 1'b0;
  logic        mute_n = 1'b1;
  logic        out_valid;
  logic [15:0] out_sample;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  zc_gain_stage u_zc_gain_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .gain_code (gain_code),
    .gain_wr   (gain_wr),
    .mute_n    (mute_n),
    .out_valid (out_valid),
    .out_sample(out_sample)
  );

  function automatic longint coef_for(input int code);
    real db;
    db = real'(code - UNITY) * 1.5;
    return longint'($rtoi(4096.0 * (10.0 ** (db / 20.0)) + 0.5));
  endfunction

  function automatic int expect_out(input int s, input int code, input bit muted);
    longint p;
    longint r;
    if (muted) return 0;
    p = longint'(s) * coef_for(code);
    r = (p + 2048) >>> 12;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_code(input int code);
    @(negedge clk);
    gain_wr = 1'b1;
    gain_code = 5'(code);
    @(negedge clk);
    gain_wr = 1'b0;
  endtask

  // One frame: drive a sample, then check the output three edges later
  task automatic send(input int s, input bit muted, input bit wr, input int wcode,
                      input int ecode, input string tag);
    int exp;
    @(negedge clk);
    check(out_valid == 1'b0, "R2", int'(out_valid), 0);
    in_valid = 1'b1;
    in_sample = 16'(s);
    mute_n = ~muted;
    gain_wr = wr;
    gain_code = 5'(wcode);
    @(negedge clk);
    in_valid = 1'b0;
    gain_wr = 1'b0;
    mute_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    exp = expect_out(s, ecode, muted);
    check(out_valid == 1'b1, "R2", int'(out_valid), 1);
    check(int'($signed(out_sample)) == exp, tag, int'($signed(out_sample)), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R4: reset state
    check(out_valid == 1'b0, "R4", int'(out_valid), 0);
    check(out_sample == 16'd0, "R4", int'($signed(out_sample)), 0);
    send(1234, 1'b0, 1'b0, 0, UNITY, "R4");
    send(-1234, 1'b0, 1'b0, 0, UNITY, "R4");

    // R1 and R3: every code over a small set of samples
    for (int c = 0; c < 32; c++) begin
      write_code(c);
      send(0, 1'b0, 1'b0, 0, c, "R1");
      send(5000, 1'b0, 1'b0, 0, c, "R1");
      send(-5000, 1'b0, 1'b0, 0, c, "R1");
      send(32767, 1'b0, 1'b0, 0, c, "R3");
      send(-32768, 1'b0, 1'b0, 0, c, "R3");
    end

    // R5 and R6: deferral until the sign changes
    write_code(UNITY);
    send(0, 1'b0, 1'b0, 0, UNITY, "R6");
    send(1000, 1'b0, 1'b0, 0, UNITY, "R1");
    write_code(31);
    send(2000, 1'b0, 1'b0, 0, UNITY, "R5");
    send(3000, 1'b0, 1'b0, 0, UNITY, "R5");
    send(-100, 1'b0, 1'b0, 0, 31, "R6");
    // R6: an exact zero counts as a crossing
    write_code(15);
    send(-200, 1'b0, 1'b0, 0, 31, "R5");
    send(0, 1'b0, 1'b0, 0, 15, "R6");
    send(500, 1'b0, 1'b0, 0, 15, "R6");
    // R5: a write alongside a sample affects only later samples
    send(-700, 1'b0, 1'b1, 7, 15, "R5");
    send(-800, 1'b0, 1'b0, 0, 15, "R5");
    send(900, 1'b0, 1'b0, 0, 7, "R6");

    // R9: muted samples are zero but still count as crossings
    write_code(27);
    send(-50, 1'b1, 1'b0, 0, 27, "R9");
    send(-9000, 1'b0, 1'b0, 0, 27, "R9");
    send(9000, 1'b1, 1'b0, 0, 27, "R9");
    send(-9000, 1'b0, 1'b0, 0, 27, "R9");

    // R7: forced update on the 256th frame without a crossing
    write_code(0);
    for (int i = 1; i < 256; i++) send(-3000, 1'b0, 1'b0, 0, 27, "R7");
    send(-3000, 1'b0, 1'b0, 0, 0, "R7");

    // R8: a rewrite replaces the pending code and restarts the count
    write_code(5);
    for (int i = 0; i < 100; i++) send(-3000, 1'b0, 1'b0, 0, 0, "R8");
    write_code(9);
    for (int i = 1; i < 256; i++) send(-3000, 1'b0, 1'b0, 0, 0, "R8");
    send(-3000, 1'b0, 1'b0, 0, 9, "R8");
    send(-3001, 1'b0, 1'b0, 0, 9, "R8");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule